// File: doc/BRIEF.md
# Per-Chip-Select Bus Rate Generator

This block paces a host-bus sequencer by producing a one-cycle clock-enable tick at a programmable rate. Up to four chip selects can each carry their own 16-bit divider count. A count of N gives one tick every N+1 clocks, so a count of 1 gives the usual half-rate pacing, where control and data changes take turns on successive clocks. A count of 0 gives a tick on every clock.

Each transfer-start strobe samples the chip-select index and picks that transfer's count. The divider restarts, so the first tick of a transfer lines up with its start. When per-chip-select rates are enabled and the new transfer's rate differs from the previous transfer's rate, the block adds one realignment cycle before counting begins. The busy output is high during that cycle. When per-chip-select rates are disabled, every chip select shares slot 0. The index-to-slot mapping is set by a dual or quad chip-select mode.

Top module: `bus_rate_gen`

## Requirements
- R1: After reset, `tick` and `rate_busy` are 0 and stay 0 until the first `xfer_start`.
- R2: With count N and no realignment, if `xfer_start` is sampled at clock edge k, `tick` is first high in the cycle after edge k+N. It is then high for one cycle in every N+1 cycles.
- R3: With count 0, `tick` is high on every cycle of the transfer.
- R4: With `per_cs_en` = 0, every chip-select index uses slot 0 (`cfg_counts[15:0]`), and `rate_busy` never rises.
- R5: With `per_cs_en` = 1 and `quad_mode` = 0, bit 0 of `cs_idx` selects the slot: 0 gives slot 0 (`cfg_counts[15:0]`) and 1 gives slot 1 (`cfg_counts[31:16]`).
- R6: With `per_cs_en` = 1 and `quad_mode` = 1, `cs_idx` value i selects slot i, which is `cfg_counts[16*i +: 16]`.
- R7: With `per_cs_en` = 1, a start whose selected count differs from the count of the previous start raises `rate_busy` for exactly the one cycle after the start edge. That start's first tick comes one cycle later than in R2.
- R8: The first start after reset never realigns, and neither does a start whose selected count equals the previous start's count.
- R9: An `xfer_start` during a running transfer restarts the divider, so the next tick follows that start's timing from R2.
- R10: Ticks continue at the selected period until the next `xfer_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Transfer-start strobe, one cycle |
| cs_idx | input | 2 | Chip-select index of the starting transfer |
| per_cs_en | input | 1 | Enable per-chip-select rates |
| quad_mode | input | 1 | 1: four chip selects, 0: two |
| cfg_counts | input | 64 | Four 16-bit divider counts, slot i at [16*i +: 16] |
| tick | output | 1 | Clock-enable tick for the sequencer |
| rate_busy | output | 1 | High during the realignment cycle |

## Verification
The embedded properties check four things on every cycle:
- The counter never exceeds the latched count.
- A nonzero count never yields two ticks in a row, and a zero count ticks continuously.
- The busy cycle lasts a single clock.
- Shared-rate mode never realigns.

Only the directed scenarios can show that the right slot is chosen for each chip-select index under each mode. The same holds for the exact first-tick latency with and without the realignment cycle, and for the restart alignment when a start arrives mid-period.

// File: rtl/bus_rate_pkg.sv
package bus_rate_pkg;
   parameter int unsigned BRG_CNT_W_DEF = 16;
   parameter int unsigned BRG_NUM_CS_DEF = 4;

   typedef enum logic [1:0] {
      SEL_SHARED = 2'd0,
      SEL_DUAL   = 2'd1,
      SEL_QUAD   = 2'd2
   } brg_sel_mode_e;
endpackage

// File: rtl/brg_count_sel.sv
module brg_count_sel
   import bus_rate_pkg::*;
#(
   parameter int unsigned CNT_W  = BRG_CNT_W_DEF,
   parameter int unsigned NUM_CS = BRG_NUM_CS_DEF,
   localparam int unsigned CS_W  = $clog2(NUM_CS)
) (
   input  logic [NUM_CS*CNT_W-1:0] counts_i,
   input  logic [CS_W-1:0]         cs_idx_i,
   input  logic                    per_cs_en_i,
   input  logic                    quad_i,
   output logic [CNT_W-1:0]        count_o
);
   brg_sel_mode_e     mode;
   logic [CS_W-1:0]   slot;
   logic [CNT_W-1:0]  slot_cnt [NUM_CS];

   for (genvar i = 0; i < NUM_CS; i++) begin : g_slot
      assign slot_cnt[i] = counts_i[i*CNT_W +: CNT_W];
   end

   if (NUM_CS == 4) begin : g_quad
      always_comb begin
         if (!per_cs_en_i)  mode = SEL_SHARED;
         else if (quad_i)   mode = SEL_QUAD;
         else               mode = SEL_DUAL;
      end
   end else begin : g_dual
      always_comb mode = per_cs_en_i ? SEL_DUAL : SEL_SHARED;
   end

   always_comb begin
      slot = '0;
      case (mode)
         SEL_DUAL: slot[0] = cs_idx_i[0];
         SEL_QUAD: slot    = cs_idx_i;
         default:  slot    = '0;
      endcase
   end

   assign count_o = slot_cnt[slot];
endmodule

// File: rtl/brg_switch_det.sv
module brg_switch_det
   import bus_rate_pkg::*;
#(
   parameter int unsigned CNT_W = BRG_CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic             per_cs_en_i,
   input  logic [CNT_W-1:0] count_i,
   output logic             adjust_o
);
   logic [CNT_W-1:0] last_q;
   logic             seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q <= '0;
         seen_q <= 1'b0;
      end else if (start_i) begin
         last_q <= count_i;
         seen_q <= 1'b1;
      end
   end

   assign adjust_o = per_cs_en_i && seen_q && (count_i != last_q);

   // R8: a start that keeps the rate leaves the remembered rate untouched
   assert_same_rate_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && seen_q && !adjust_o && per_cs_en_i) |=> $stable(last_q));
endmodule

// File: rtl/brg_divider.sv
module brg_divider
   import bus_rate_pkg::*;
#(
   parameter int unsigned CNT_W = BRG_CNT_W_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] load_i,
   input  logic             adjust_i,
   output logic             tick_o,
   output logic             busy_o
);
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] reload_q;
   logic             run_q;
   logic             hold_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         reload_q <= '0;
         run_q    <= 1'b0;
         hold_q   <= 1'b0;
      end else if (start_i) begin
         cnt_q    <= load_i;
         reload_q <= load_i;
         run_q    <= 1'b1;
         hold_q   <= adjust_i;
      end else if (run_q) begin
         if (hold_q)             hold_q <= 1'b0;
         else if (cnt_q == '0)   cnt_q  <= reload_q;
         else                    cnt_q  <= cnt_q - 1'b1;
      end
   end

   assign tick_o = run_q && !hold_q && (cnt_q == '0);
   assign busy_o = hold_q;

   // R2: counter stays within the latched count
   assert_cnt_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run_q |-> (cnt_q <= reload_q));
   // R2: a nonzero count never gives back-to-back ticks
   assert_no_double_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_o && !start_i && reload_q != '0) |=> !tick_o);
   // R3: a zero count ticks on every cycle once counting
   assert_zero_count_ticks_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !hold_q && reload_q == '0 && !start_i) |=> tick_o);
   // R7: realignment lasts a single cycle
   assert_busy_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && !start_i) |=> !busy_o);
endmodule

// File: rtl/bus_rate_gen.sv
module bus_rate_gen
   import bus_rate_pkg::*;
#(
   parameter int unsigned CNT_W  = BRG_CNT_W_DEF,
   parameter int unsigned NUM_CS = BRG_NUM_CS_DEF,
   localparam int unsigned CS_W  = $clog2(NUM_CS),
   localparam int unsigned CFG_W = NUM_CS * CNT_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             xfer_start,
   input  logic [CS_W-1:0]  cs_idx,
   input  logic             per_cs_en,
   input  logic             quad_mode,
   input  logic [CFG_W-1:0] cfg_counts,
   output logic             tick,
   output logic             rate_busy
);
   initial begin
      assert (NUM_CS == 2 || NUM_CS == 4)
         else $error("bus_rate_gen: NUM_CS must be 2 or 4");
      assert (CNT_W >= 1 && CNT_W <= 32)
         else $error("bus_rate_gen: CNT_W out of range");
   end

   logic [CNT_W-1:0] sel_count;
   logic             need_adjust;

   brg_count_sel #(.CNT_W(CNT_W), .NUM_CS(NUM_CS)) u_sel (
      .counts_i    (cfg_counts),
      .cs_idx_i    (cs_idx),
      .per_cs_en_i (per_cs_en),
      .quad_i      (quad_mode),
      .count_o     (sel_count)
   );

   brg_switch_det #(.CNT_W(CNT_W)) u_switch (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (xfer_start),
      .per_cs_en_i (per_cs_en),
      .count_i     (sel_count),
      .adjust_o    (need_adjust)
   );

   brg_divider #(.CNT_W(CNT_W)) u_div (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (xfer_start),
      .load_i   (sel_count),
      .adjust_i (need_adjust),
      .tick_o   (tick),
      .busy_o   (rate_busy)
   );

   // R4: shared-rate mode never realigns
   assert_shared_no_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_start && !per_cs_en) |=> !rate_busy);
endmodule

// File: tb/bus_rate_gen_tb_top.sv
module bus_rate_gen_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        xfer_start = 1'b0;
   logic [1:0]  cs_idx = '0;
   logic        per_cs_en = 1'b0;
   logic        quad_mode = 1'b0;
   logic [63:0] cfg_counts = '0;
   logic        tick;
   logic        rate_busy;
   int          n_cmp = 0;
   int          n_bad = 0;

   always #10 clk = ~clk;

   bus_rate_gen dut_i (
      .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .cs_idx(cs_idx),
      .per_cs_en(per_cs_en), .quad_mode(quad_mode), .cfg_counts(cfg_counts),
      .tick(tick), .rate_busy(rate_busy)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      xfer_start = 1'b0;
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic set_slots(input int s0, input int s1, input int s2, input int s3);
      cfg_counts = {16'(s3), 16'(s2), 16'(s1), 16'(s0)};
   endtask

   // drive one start; returns at the negedge just after the sampling edge (j=0)
   task automatic start_xfer(input int cs);
      cs_idx = 2'(cs);
      xfer_start = 1'b1;
      @(negedge clk);
      xfer_start = 1'b0;
   endtask

   task automatic measure(input string tag, input int exp_first, input int period,
                          input int exp_busy);
      int t1 = -1;
      int t2 = -1;
      for (int j = 0; j <= exp_first + period + 1; j++) begin
         if (j == 0) check({tag, " busy after start"}, int'(rate_busy), exp_busy);
         if (j == 1) check({tag, " busy cleared"}, int'(rate_busy), 0);
         if (tick) begin
            if (t1 < 0) t1 = j;
            else if (t2 < 0) t2 = j;
         end
         if (j != exp_first + period + 1) @(negedge clk);
      end
      check({tag, " first tick"}, t1, exp_first);
      check({tag, " period"}, (t2 < 0) ? -1 : t2 - t1, period);
   endtask

   task automatic t_reset();
      int ticks = 0;
      int busy = 0;
      do_reset();
      for (int j = 0; j < 20; j++) begin
         ticks += int'(tick);
         busy += int'(rate_busy);
         @(negedge clk);
      end
      check("R1 no tick before start", ticks, 0);
      check("R1 no busy before start", busy, 0);
   endtask

   task automatic t_shared();
      do_reset();
      per_cs_en = 1'b0; quad_mode = 1'b1;
      set_slots(3, 7, 9, 11);
      start_xfer(2);
      measure("R4 R2 shared cs2", 3, 4, 0);
      start_xfer(1);
      measure("R4 shared cs1", 3, 4, 0);
   endtask

   task automatic t_zero();
      do_reset();
      per_cs_en = 1'b0;
      set_slots(0, 5, 5, 5);
      start_xfer(0);
      measure("R3 zero count", 0, 1, 0);
   endtask

   task automatic t_dual();
      do_reset();
      per_cs_en = 1'b1; quad_mode = 1'b0;
      set_slots(2, 5, 12, 13);
      start_xfer(0);
      measure("R5 R8 dual cs0 first", 2, 3, 0);
      start_xfer(1);
      measure("R5 R7 dual cs1 switch", 6, 6, 1);
      start_xfer(3);
      measure("R5 R8 dual cs3 same rate", 5, 6, 0);
      start_xfer(2);
      measure("R5 R7 dual cs2 switch", 3, 3, 1);
   endtask

   task automatic t_quad();
      do_reset();
      per_cs_en = 1'b1; quad_mode = 1'b1;
      set_slots(1, 4, 6, 9);
      start_xfer(2);
      measure("R6 quad cs2", 6, 7, 0);
      start_xfer(3);
      measure("R6 R7 quad cs3 switch", 10, 10, 1);
      start_xfer(3);
      measure("R6 R8 quad cs3 repeat", 9, 10, 0);
      start_xfer(0);
      measure("R6 R7 quad cs0 switch", 2, 2, 1);
   endtask

   task automatic t_restart();
      int ticks = 0;
      do_reset();
      per_cs_en = 1'b0;
      set_slots(5, 0, 0, 0);
      start_xfer(0);
      repeat (3) @(negedge clk);
      start_xfer(0);
      measure("R9 restart mid period", 5, 6, 0);
      do_reset();
      set_slots(4, 0, 0, 0);
      start_xfer(0);
      for (int j = 0; j < 30; j++) begin
         ticks += int'(tick);
         @(negedge clk);
      end
      check("R10 ticks keep running", ticks, 6);
   endtask

   initial begin
      t_reset();
      t_shared();
      t_zero();
      t_dual();
      t_quad();
      t_restart();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule